// File: doc/BRIEF.md
# Sleep Wake-Up Source Controller

This block decides when a small metering-style microcontroller leaves a low-power state. Firmware moves the chip from normal running into either a full sleep state or a display-only state by pulsing one of two request inputs. While in either of those states, the block watches a set of already-debounced digital pins, a push-button and a serial receive line. It also runs an 8-bit wake timer that counts whole seconds from a 1 Hz tick. The first qualifying event produces a one-cycle wake pulse and returns the block to the running state.

Each wake source owns a sticky flag that firmware reads after waking to learn why the chip woke. Pin flags are rising-edge latches that are kept at zero while their pin is not enabled as a wake source. The timer has to be armed by a register write before each use. Arming loads the reload value, and the timed interval is that value plus one seconds. All flags clear when firmware pulses a clear strobe and whenever a new low-power entry happens.

Top module: `slpwk_ctrl`

## Requirements
- R1: After reset, `lp_mode` is 0 (running), `wake_pulse` is 0, all flags are 0 and the timer is disarmed.
- R2: `lp_mode` encodes 0 = running, 1 = sleep, 2 = display-only. From running, `sleep_req` enters 1 and `lcd_req` enters 2 on the next clock; when both are high, sleep wins. A request made while not running leaves `lp_mode` unchanged.
- R3: A pulse on `arm_wr` loads the counter from `reload_val` and arms the timer, and this works in any mode. Entering a low-power mode with the timer disarmed never produces a timed wake.
- R4: An armed timer counts `tick_1hz` pulses only while `lp_mode` is not 0. Ticks seen while running are not counted. A reload value of N wakes on the (N+1)th counted tick.
- R5: When the timer expires, `wake_pulse` is high for exactly one cycle, `tmr_flag` sets and `lp_mode` returns to 0, all on the clock edge that sees the final tick. The timer is then disarmed until it is armed again.
- R6: A rising edge on `wake_pin[i]` with `wake_pin_en[i]` high sets `pin_flags[i]` on the next clock in any mode. In a low-power mode it also causes a wake.
- R7: `pin_flags[i]` is 0 whenever `wake_pin_en[i]` was low on the previous clock. A rising edge on a disabled pin neither sets its flag nor wakes the chip.
- R8: In a low-power mode, a rising edge on `button` or `rx_line` wakes the chip and sets `btn_flag` or `rx_flag` respectively. While running, those edges set no flag.
- R9: A `flag_clr_wr` pulse clears every flag on the next clock. A flag whose set event lands in the same cycle as the clear ends up set.
- R10: Entering a low-power mode clears every flag, in the same way as `flag_clr_wr`.
- R11: A wake from any source disarms the timer, so a later low-power entry that is not re-armed produces no timed wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse each second |
| sleep_req | input | 1 | Request to enter sleep mode |
| lcd_req | input | 1 | Request to enter display-only mode |
| arm_wr | input | 1 | Write strobe that arms the timer and loads the reload value |
| reload_val | input | TW (8) | Timer reload value N; the interval is N+1 seconds |
| wake_pin | input | NPIN (3) | Debounced wake-capable pins |
| wake_pin_en | input | NPIN (3) | Per-pin enable for wake |
| button | input | 1 | Debounced push-button |
| rx_line | input | 1 | Debounced serial receive line |
| flag_clr_wr | input | 1 | Write strobe that clears all flags |
| wake_pulse | output | 1 | One-cycle wake indication |
| lp_mode | output | 2 | Current mode (0 run, 1 sleep, 2 display-only) |
| pin_flags | output | NPIN (3) | Per-pin wake flags |
| tmr_flag | output | 1 | Timer caused a wake |
| btn_flag | output | 1 | Push-button caused a wake |
| rx_flag | output | 1 | Serial receive line caused a wake |

## Verification
If the counter has the wrong value, the wake pulse appears one or more ticks off the N+1 position, and the counted ticks make this visible at the port within a second of simulated ticks. If the armed bit is left set after a wake, a spurious timed wake follows the next non-armed entry after that many ticks. A flag-update fault shows on the very next clock edge, either as a flag still set after a clear or entry, as a flag set from a disabled pin, or as a missing flag after an edge that should have set it. A mode-register fault shows one edge after a request or a wake, in `lp_mode` and in whether the next source edge produces a pulse.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;
  typedef enum logic [1:0] {
    LPM_RUN   = 2'd0,
    LPM_SLEEP = 2'd1,
    LPM_LCD   = 2'd2
  } lpm_e;

  // a sticky flag: a set in the same cycle as a clear wins
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic rise_of(logic cur, logic prev);
    return cur & ~prev;
  endfunction
endpackage

// File: rtl/slpwk_edge_bank.sv
module slpwk_edge_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise
);
  import slpwk_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    // prev starts high so a source already high at reset is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sig[g];
    end
    assign rise[g] = rise_of(sig[g], prev_q);
  end
endmodule

// File: rtl/slpwk_timer.sv
module slpwk_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_wr,
  input  logic [TW-1:0] reload,
  input  logic          run,
  input  logic          tick,
  input  logic          wake_evt,
  output logic          expire,
  output logic          armed
);
  logic [TW-1:0] cnt_q;
  logic          count_en;
  logic          at_zero;

  function automatic logic [TW-1:0] dec_cnt(logic [TW-1:0] v);
    return v - {{(TW-1){1'b0}}, 1'b1};
  endfunction

  assign count_en = run & armed & tick;
  assign at_zero  = (cnt_q == '0);
  assign expire   = count_en & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      armed <= 1'b0;
    end else if (arm_wr) begin
      cnt_q <= reload;
      armed <= 1'b1;
    end else begin
      if (count_en && !at_zero) cnt_q <= dec_cnt(cnt_q);
      if (wake_evt)             armed <= 1'b0;
    end
  end

  // R4
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !at_zero && !arm_wr) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R11
  disarm_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !arm_wr) |=> !armed);

  // R3
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> (armed && cnt_q == $past(reload)));
endmodule

// File: rtl/slpwk_flags.sv
module slpwk_flags #(
  parameter int NPIN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_en,
  input  logic [NPIN-1:0] pin_rise,
  input  logic            tmr_set,
  input  logic            btn_set,
  input  logic            rx_set,
  input  logic            clr,
  output logic [NPIN-1:0] pin_flags,
  output logic            tmr_flag,
  output logic            btn_flag,
  output logic            rx_flag
);
  import slpwk_pkg::*;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_flags[g] <= 1'b0;
      else        pin_flags[g] <= pin_en[g] &
                    flag_next(pin_flags[g], pin_rise[g], clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_flag <= 1'b0;
      btn_flag <= 1'b0;
      rx_flag  <= 1'b0;
    end else begin
      tmr_flag <= flag_next(tmr_flag, tmr_set, clr);
      btn_flag <= flag_next(btn_flag, btn_set, clr);
      rx_flag  <= flag_next(rx_flag,  rx_set,  clr);
    end
  end

  // R7
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_flags & ~$past(pin_en)) == '0);

  // R9
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tmr_set && !btn_set && !rx_set) |=> (!tmr_flag && !btn_flag && !rx_flag));
endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl #(
  parameter int NPIN = 3,
  parameter int TW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_1hz,
  input  logic            sleep_req,
  input  logic            lcd_req,
  input  logic            arm_wr,
  input  logic [TW-1:0]   reload_val,
  input  logic [NPIN-1:0] wake_pin,
  input  logic [NPIN-1:0] wake_pin_en,
  input  logic            button,
  input  logic            rx_line,
  input  logic            flag_clr_wr,
  output logic            wake_pulse,
  output logic [1:0]      lp_mode,
  output logic [NPIN-1:0] pin_flags,
  output logic            tmr_flag,
  output logic            btn_flag,
  output logic            rx_flag
);
  import slpwk_pkg::*;

  localparam int NSRC = NPIN + 2;

  lpm_e            mode_q;
  logic [NSRC-1:0] src_rise;
  logic [NPIN-1:0] pin_rise;
  logic            btn_rise;
  logic            rx_rise;
  logic            low_pwr;
  logic            entry;
  logic            pin_wake;
  logic            expire;
  logic            armed;
  logic            wake_evt;

  slpwk_edge_bank #(.N(NSRC)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   ({rx_line, button, wake_pin}),
    .rise  (src_rise)
  );

  assign pin_rise = src_rise[NPIN-1:0];
  assign btn_rise = src_rise[NPIN];
  assign rx_rise  = src_rise[NPIN+1];

  assign low_pwr  = (mode_q != LPM_RUN);
  assign entry    = (mode_q == LPM_RUN) & (sleep_req | lcd_req);
  assign pin_wake = |(pin_rise & wake_pin_en);
  assign wake_evt = low_pwr & (pin_wake | btn_rise | rx_rise | expire);

  slpwk_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_wr   (arm_wr),
    .reload   (reload_val),
    .run      (low_pwr),
    .tick     (tick_1hz),
    .wake_evt (wake_evt),
    .expire   (expire),
    .armed    (armed)
  );

  slpwk_flags #(.NPIN(NPIN)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_en    (wake_pin_en),
    .pin_rise  (pin_rise),
    .tmr_set   (expire),
    .btn_set   (low_pwr & btn_rise),
    .rx_set    (low_pwr & rx_rise),
    .clr       (flag_clr_wr | entry),
    .pin_flags (pin_flags),
    .tmr_flag  (tmr_flag),
    .btn_flag  (btn_flag),
    .rx_flag   (rx_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= LPM_RUN;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= wake_evt;
      if (wake_evt)   mode_q <= LPM_RUN;
      else if (entry) mode_q <= sleep_req ? LPM_SLEEP : LPM_LCD;
    end
  end

  assign lp_mode = mode_q;

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R5
  pulse_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (lp_mode == 2'd0));

  // R5
  expire_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (wake_pulse && tmr_flag));

  // R2
  entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (lp_mode == (($past(sleep_req)) ? 2'd1 : 2'd2)));

  // R10
  entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && !pin_wake) |=> (pin_flags == '0 && !tmr_flag && !btn_flag && !rx_flag));

  // R8
  run_no_src_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_pwr && !flag_clr_wr && !entry) |=> ($stable(btn_flag) && $stable(rx_flag)));
endmodule

// File: tb/slpwk_ctrl_test.sv
module slpwk_ctrl_test;
  localparam int NPIN = 3;
  localparam int TW   = 8;

  typedef enum int {F_PULSE, F_MODE, F_PINF, F_TMRF, F_BTNF, F_RXF} fld_e;
  typedef struct {
    int unsigned cyc;
    fld_e        f;
    logic [7:0]  v;
    string       tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick_1hz = 1'b0, sleep_req = 1'b0, lcd_req = 1'b0, arm_wr = 1'b0;
  logic [TW-1:0]   reload_val = '0;
  logic [NPIN-1:0] wake_pin = '0, wake_pin_en = '0;
  logic            button = 1'b0, rx_line = 1'b0, flag_clr_wr = 1'b0;
  logic            wake_pulse, tmr_flag, btn_flag, rx_flag;
  logic [1:0]      lp_mode;
  logic [NPIN-1:0] pin_flags;

  int unsigned cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slpwk_ctrl #(.NPIN(NPIN), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .sleep_req(sleep_req),
    .lcd_req(lcd_req), .arm_wr(arm_wr), .reload_val(reload_val),
    .wake_pin(wake_pin), .wake_pin_en(wake_pin_en), .button(button),
    .rx_line(rx_line), .flag_clr_wr(flag_clr_wr), .wake_pulse(wake_pulse),
    .lp_mode(lp_mode), .pin_flags(pin_flags), .tmr_flag(tmr_flag),
    .btn_flag(btn_flag), .rx_flag(rx_flag)
  );

  function automatic logic [7:0] read_fld(fld_e f);
    case (f)
      F_PULSE: return {7'd0, wake_pulse};
      F_MODE:  return {6'd0, lp_mode};
      F_PINF:  return {5'd0, pin_flags};
      F_TMRF:  return {7'd0, tmr_flag};
      F_BTNF:  return {7'd0, btn_flag};
      default: return {7'd0, rx_flag};
    endcase
  endfunction

  // monitor: compare every queued item whose cycle has come
  always @(posedge clk) begin
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc <= cyc) begin
        logic [7:0] act;
        act = read_fld(q[i].f);
        n_cmp++;
        if (q[i].cyc != cyc || act !== q[i].v) begin
          n_bad++;
          $display("FAIL %s field=%0d actual=%0d expected=%0d", q[i].tag, q[i].f, act, q[i].v);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_at(int dly, fld_e f, logic [7:0] v, string tag);
    exp_t e;
    e.cyc = cyc + dly; e.f = f; e.v = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_tick(logic exp_pulse, string tag);
    tick_1hz = 1'b1;
    expect_at(1, F_PULSE, {7'd0, exp_pulse}, tag);
    step();
    tick_1hz = 1'b0;
  endtask

  task automatic arm(logic [TW-1:0] n);
    reload_val = n; arm_wr = 1'b1; step(); arm_wr = 1'b0;
  endtask

  task automatic enter(bit lcd, string tag);
    if (lcd) lcd_req = 1'b1; else sleep_req = 1'b1;
    expect_at(1, F_MODE, lcd ? 8'd2 : 8'd1, tag);
    step();
    lcd_req = 1'b0; sleep_req = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state
    expect_at(1, F_MODE, 0, "R1"); expect_at(1, F_PULSE, 0, "R1");
    expect_at(1, F_PINF, 0, "R1"); expect_at(1, F_TMRF, 0, "R1");
    expect_at(1, F_BTNF, 0, "R1"); expect_at(1, F_RXF, 0, "R1");
    step(); step();

    // R4 R5: arm N=3, ticks in run ignored, wake on 4th counted tick
    arm(8'd3);
    do_tick(1'b0, "R4 run tick ignored");
    do_tick(1'b0, "R4 run tick ignored");
    enter(1'b0, "R2 sleep entry");
    do_tick(1'b0, "R4 tick1"); do_tick(1'b0, "R4 tick2"); do_tick(1'b0, "R4 tick3");
    expect_at(1, F_TMRF, 1, "R5 tmr flag");
    expect_at(1, F_MODE, 0, "R5 back to run");
    expect_at(2, F_PULSE, 0, "R5 single pulse");
    do_tick(1'b1, "R4 tick4 wakes");
    step();

    // R10 R3: display-only entry clears flags, no timed wake without arming
    expect_at(1, F_TMRF, 0, "R10 entry clears");
    enter(1'b1, "R2 lcd entry");
    for (int k = 0; k < 5; k++) do_tick(1'b0, "R3 disarmed no wake");
    expect_at(1, F_MODE, 2, "R3 still asleep");
    step();

    // R6 enabled pin wakes
    wake_pin_en = 3'b010; step();
    wake_pin[1] = 1'b1;
    expect_at(1, F_PINF, 8'd2, "R6 pin flag");
    expect_at(1, F_PULSE, 1, "R6 pin wake");
    expect_at(1, F_MODE, 0, "R6 pin wake mode");
    step();
    wake_pin[1] = 1'b0; step();

    // R7 disabled pin ignored; R8 button wakes
    expect_at(1, F_PINF, 0, "R10 entry clears pin");
    enter(1'b0, "R2 sleep entry");
    wake_pin[0] = 1'b1;
    expect_at(1, F_PINF, 0, "R7 disabled pin no flag");
    expect_at(1, F_PULSE, 0, "R7 disabled pin no wake");
    expect_at(1, F_MODE, 1, "R7 still asleep");
    step();
    button = 1'b1;
    expect_at(1, F_BTNF, 1, "R8 button flag");
    expect_at(1, F_PULSE, 1, "R8 button wake");
    expect_at(1, F_MODE, 0, "R8 button mode");
    step();
    button = 1'b0; step();

    // R8 rx edge in run sets nothing; in sleep wakes
    rx_line = 1'b1;
    expect_at(1, F_RXF, 0, "R8 rx in run");
    expect_at(1, F_PULSE, 0, "R8 rx in run");
    step();
    rx_line = 1'b0; step();
    enter(1'b0, "R2 sleep entry");
    rx_line = 1'b1;
    expect_at(1, F_RXF, 1, "R8 rx flag");
    expect_at(1, F_PULSE, 1, "R8 rx wake");
    step();
    rx_line = 1'b0;

    // R6 pin flag in run mode, R7 disable clears it
    wake_pin_en = 3'b001; wake_pin[0] = 1'b0; step();
    wake_pin[0] = 1'b1;
    expect_at(1, F_PINF, 1, "R6 pin flag in run");
    expect_at(1, F_PULSE, 0, "R6 no wake in run");
    step();
    wake_pin_en = 3'b000;
    expect_at(1, F_PINF, 0, "R7 disable clears");
    step();

    // R9 clear strobe, and set beats clear
    flag_clr_wr = 1'b1;
    expect_at(1, F_RXF, 0, "R9 clear rx");
    expect_at(1, F_BTNF, 0, "R9 clear btn");
    step();
    flag_clr_wr = 1'b0;
    wake_pin_en = 3'b001; wake_pin[0] = 1'b0; step();
    wake_pin[0] = 1'b1; flag_clr_wr = 1'b1;
    expect_at(1, F_PINF, 1, "R9 set wins");
    step();
    flag_clr_wr = 1'b0; step();

    // R11 wake by button disarms the timer
    arm(8'd5);
    enter(1'b0, "R2 sleep entry");
    do_tick(1'b0, "R11 count"); do_tick(1'b0, "R11 count");
    button = 1'b1;
    expect_at(1, F_PULSE, 1, "R11 button wake");
    step();
    button = 1'b0; step();
    enter(1'b0, "R2 sleep entry");
    for (int k = 0; k < 8; k++) do_tick(1'b0, "R11 disarmed after wake");
    expect_at(1, F_TMRF, 0, "R11 no timer flag");
    expect_at(1, F_MODE, 1, "R11 still asleep");
    step();

    // R3 arm while asleep, N=0 wakes on the first tick
    arm(8'd0);
    expect_at(1, F_TMRF, 1, "R3 N=0 tmr flag");
    expect_at(1, F_MODE, 0, "R3 N=0 wake mode");
    do_tick(1'b1, "R3 N=0 one tick");
    step();

    // R2 both requests: sleep wins; request while asleep ignored
    sleep_req = 1'b1; lcd_req = 1'b1;
    expect_at(1, F_MODE, 1, "R2 sleep priority");
    step();
    sleep_req = 1'b0;
    expect_at(1, F_MODE, 1, "R2 request ignored asleep");
    step();
    lcd_req = 1'b0;
    rx_line = 1'b1;
    expect_at(1, F_MODE, 0, "R8 rx wake");
    step();
    rx_line = 1'b0;

    repeat (5) step();
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL queue not drained actual=%0d expected=0", q.size());
    end
    finish_up();
  end
endmodule